// File: doc/BRIEF.md
# Parallel-Port Slice Protocol Engine

This block lets a host on a narrow, slow byte-wide link read and write a word-addressed memory. The host drives an 8-bit input byte and reads back a 4-bit status nibble. Every operation is cut into four slices. A slice is marked by a change of level on the top bit of the byte, never by the level itself. The Read and Write bits, held for the first three slices and dropped to zero on the fourth, choose the operation: set the current address, write a word, read a word, or apply settings. Apply settings is a short sequence of its own that loads a small flag register.

The engine keeps a current-address register and steps it by one after every completed memory access. Settings flag 0 gives the host ownership of the memory. While that flag is clear, host reads and writes are decoded but never reach memory. The memory side is a valid/ready request channel with a separate response strobe. A request holds all of its fields stable until ready is seen. Read data is captured from the first response pulse and cannot be back-pressured.

Top module: `pport_slice_engine`

## Requirements
- R1: Host byte map: bit 7 is the slice strobe, bit 6 Read, bit 5 Write, bits 4:0 slice data. A slice is taken only when bit 7 changes. An operation starts only on a change of bit 7 to 1. Changes on the other bits with bit 7 steady start nothing.
- R2: Read=1 and Write=1 on slices 1–3, then Read=Write=0 on slice 4, sets the current address. Slice data bits 4:0 supply address bits 4:0, 9:5 and 14:10, and data bits 3:0 of slice 4 supply bits 18:15.
- R3: Write=1 alone on slices 1–3, then 0 on slice 4, writes one word. Data bits 3:0 of the slices give nibbles 3:0, 7:4, 11:8 and 15:12 in turn. Exactly one write request for the assembled word goes to the current address after slice 4.
- R4: Read=1 alone on slices 1–3, then 0 on slice 4, issues one read request at the current address on slice 1. The status output shows word bits 3:0 once the data returns, then bits 7:4, 11:8 and 15:12 after slices 2, 3 and 4. The status holds its value between slices.
- R5: The current address grows by one, wrapping at 2^19, after each accepted write request and after each read response.
- R6: Apply settings works as follows. A slice with the strobe at 1 and Read=Write=0 comes first, then a slice with the strobe at 0 and Read=Write=0. Write then rises and falls with the strobe held. On the fall, data bits 4:0 load the flag register. The flags are held at all other times.
- R7: While flag 0 is clear, no memory request is raised. A host read shows status 0 on all four slices, and the current address does not move.
- R8: A slice whose Read/Write bits do not fit the operation in progress abandons it. This means 11, 01 or 10 must be held on slices 2–3 and 00 must come on slice 4. The engine returns to idle with no memory request and the address unchanged.
- R9: A request keeps valid, address, write-enable and write data stable until ready is high. Each host write or read gives exactly one accepted request.
- R10: After reset the flags, current address and status are 0 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_in | input | 8 | Host byte (asynchronous) |
| host_status | output | 4 | Read nibble returned to host |
| ctrl_flags | output | 5 | Settings register |
| host_owns_mem | output | 1 | Flag 0: host may access memory |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 19 | Request word address |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Read data valid, one pulse per read |
| mem_rsp_data | input | 16 | Read data |

## Verification
A change of the host byte is acted on at the fourth rising edge after it is driven: two synchroniser stages, one change-detect stage and the engine register. A status nibble for slices 2–4, a new flag value, and the raising of a request all become visible right after that edge. The first read nibble and a request's acceptance also depend on ready and on the two-cycle response of the bench memory. For that reason the bench holds each byte for 8 cycles, or 16 when memory is involved, and samples on the falling edge at the end of that window. Address, data and ownership results are then checked against values computed arithmetically, including sweeps over every single-bit address and over sixteen sequential words.

// File: rtl/pse_pkg.sv
package pse_pkg;
  localparam int STB_BIT = 7;
  localparam int RD_BIT  = 6;
  localparam int WR_BIT  = 5;
  localparam int NSLICE  = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WDAT,
    ST_RDAT,
    ST_SET1,
    ST_SET2,
    ST_SET3,
    ST_MWR,
    ST_MRD_REQ,
    ST_MRD_WAIT
  } eng_state_t;
endpackage

// File: rtl/pse_sync.sv
module pse_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pse_slice_detect.sv
module pse_slice_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_lvl,
  input  logic wr_lvl,
  output logic stb_evt,
  output logic wr_evt
);
  logic stb_prev, wr_prev;

  // events are registered so the engine samples the byte one clock after the change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_prev <= 1'b0;
      wr_prev  <= 1'b0;
      stb_evt  <= 1'b0;
      wr_evt   <= 1'b0;
    end else begin
      stb_prev <= stb_lvl;
      wr_prev  <= wr_lvl;
      stb_evt  <= stb_lvl ^ stb_prev;
      wr_evt   <= wr_lvl ^ wr_prev;
    end
  end
endmodule

// File: rtl/pport_slice_engine.sv
module pport_slice_engine
  import pse_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 16,
  parameter int NIB_W   = 4,
  parameter int SLICE_W = 5,
  parameter int FLAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        host_in,
  output logic [NIB_W-1:0]  host_status,
  output logic [FLAG_W-1:0] ctrl_flags,
  output logic              host_owns_mem,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int IDX_W   = $clog2(NSLICE);
  localparam int LAST    = NSLICE - 1;
  localparam int ALOW_W  = LAST * SLICE_W;
  localparam int AHIGH_W = ADDR_W - ALOW_W;
  localparam int DLOW_W  = DATA_W - NIB_W;

  logic [7:0] host_sync;
  logic       slice_pulse, wr_pulse;

  pse_sync #(.W(8)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (host_in),
    .q     (host_sync)
  );

  pse_slice_detect u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb_lvl (host_sync[STB_BIT]),
    .wr_lvl  (host_sync[WR_BIT]),
    .stb_evt (slice_pulse),
    .wr_evt  (wr_pulse)
  );

  logic               stb_b;
  logic [1:0]         rw_b;
  logic [SLICE_W-1:0] dat_b;
  assign stb_b = host_sync[STB_BIT];
  assign rw_b  = {host_sync[RD_BIT], host_sync[WR_BIT]};
  assign dat_b = host_sync[SLICE_W-1:0];

  eng_state_t          state;
  logic [IDX_W-1:0]    idx;
  logic [1:0]          op_rw;
  logic [ADDR_W-1:0]   cur_addr;
  logic [ALOW_W-1:0]   addr_acc;
  logic [DLOW_W-1:0]   data_acc;
  logic [DATA_W-1:0]   wdata_q;
  logic [DATA_W-1:0]   rd_word;
  logic [NIB_W-1:0]    status_q;
  logic [FLAG_W-1:0]   flags_q;

  logic       is_last;
  logic [1:0] exp_rw;
  logic       rw_ok;
  assign is_last = (idx == IDX_W'(LAST));
  assign exp_rw  = is_last ? 2'b00 : op_rw;
  assign rw_ok   = (rw_b == exp_rw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      op_rw    <= 2'b00;
      cur_addr <= '0;
      addr_acc <= '0;
      data_acc <= '0;
      wdata_q  <= '0;
      rd_word  <= '0;
      status_q <= '0;
      flags_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (slice_pulse && stb_b) begin
            op_rw <= rw_b;
            idx   <= IDX_W'(1);
            unique case (rw_b)
              2'b11: begin
                addr_acc[SLICE_W-1:0] <= dat_b;
                state <= ST_ADDR;
              end
              2'b01: begin
                data_acc[NIB_W-1:0] <= dat_b[NIB_W-1:0];
                state <= ST_WDAT;
              end
              2'b10: begin
                if (flags_q[0]) begin
                  state <= ST_MRD_REQ;
                end else begin
                  rd_word  <= '0;
                  status_q <= '0;
                  state    <= ST_RDAT;
                end
              end
              default: state <= ST_SET1;
            endcase
          end
        end
        ST_ADDR: begin
          if (slice_pulse) begin
            if (!rw_ok) begin
              state <= ST_IDLE;
            end else if (is_last) begin
              cur_addr <= {dat_b[AHIGH_W-1:0], addr_acc};
              state    <= ST_IDLE;
            end else begin
              addr_acc[idx*SLICE_W +: SLICE_W] <= dat_b;
              idx <= idx + 1'b1;
            end
          end
        end
        ST_WDAT: begin
          if (slice_pulse) begin
            if (!rw_ok) begin
              state <= ST_IDLE;
            end else if (is_last) begin
              wdata_q <= {dat_b[NIB_W-1:0], data_acc};
              state   <= flags_q[0] ? ST_MWR : ST_IDLE;
            end else begin
              data_acc[idx*NIB_W +: NIB_W] <= dat_b[NIB_W-1:0];
              idx <= idx + 1'b1;
            end
          end
        end
        ST_RDAT: begin
          if (slice_pulse) begin
            if (!rw_ok) begin
              state <= ST_IDLE;
            end else begin
              status_q <= rd_word[idx*NIB_W +: NIB_W];
              if (is_last) state <= ST_IDLE;
              else         idx   <= idx + 1'b1;
            end
          end
        end
        ST_MWR: begin
          if (mem_req_ready) begin
            cur_addr <= cur_addr + 1'b1;
            state    <= ST_IDLE;
          end
        end
        ST_MRD_REQ: begin
          if (mem_req_ready) state <= ST_MRD_WAIT;
        end
        ST_MRD_WAIT: begin
          if (mem_rsp_valid) begin
            rd_word  <= mem_rsp_data;
            status_q <= mem_rsp_data[NIB_W-1:0];
            cur_addr <= cur_addr + 1'b1;
            state    <= ST_RDAT;
          end
        end
        ST_SET1: begin
          if (slice_pulse) state <= (!stb_b && rw_b == 2'b00) ? ST_SET2 : ST_IDLE;
        end
        ST_SET2: begin
          if (slice_pulse)                        state <= ST_IDLE;
          else if (wr_pulse && rw_b == 2'b01)     state <= ST_SET3;
        end
        ST_SET3: begin
          if (slice_pulse) begin
            state <= ST_IDLE;
          end else if (wr_pulse && rw_b == 2'b00) begin
            flags_q <= dat_b[FLAG_W-1:0];
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state == ST_MWR) || (state == ST_MRD_REQ);
  assign mem_req_we    = (state == ST_MWR);
  assign mem_req_addr  = cur_addr;
  assign mem_req_wdata = wdata_q;
  assign host_status   = status_q;
  assign ctrl_flags    = flags_q;
  assign host_owns_mem = flags_q[0];

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata)); // R9

  AST_LOCKED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !host_owns_mem |-> !mem_req_valid); // R7

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && mem_req_we |=> mem_req_addr == $past(mem_req_addr) + 1'b1); // R5

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_RDAT && !slice_pulse |=> $stable(host_status)); // R4

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    state != ST_SET3 |=> $stable(ctrl_flags)); // R6
endmodule

// File: tb/pport_slice_engine_tb.sv
module pport_slice_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_in = 8'h00;
  logic [3:0]  host_status;
  logic [4:0]  ctrl_flags;
  logic        host_owns_mem;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [18:0] mem_req_addr;
  logic [15:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  pport_slice_engine u_dut (
    .clk(clk), .rst_n(rst_n), .host_in(host_in), .host_status(host_status),
    .ctrl_flags(ctrl_flags), .host_owns_mem(host_owns_mem),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  // memory model: stalls one cycle in three, answers reads two cycles later
  logic [15:0] mem [0:63];
  int          wr_cnt = 0, rd_cnt = 0, cyc = 0;
  logic [18:0] last_addr = '0;
  logic [15:0] last_wdata = '0;
  logic        p1_v = 1'b0;
  logic [15:0] p1_d = '0;
  int total = 0, bad = 0;

  initial for (int i = 0; i < 64; i++) mem[i] = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
    p1_v <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      last_addr <= mem_req_addr;
      if (mem_req_we) begin
        mem[mem_req_addr[5:0]] <= mem_req_wdata;
        last_wdata <= mem_req_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        p1_v <= 1'b1;
        p1_d <= mem[mem_req_addr[5:0]];
        rd_cnt <= rd_cnt + 1;
      end
    end
    mem_rsp_valid <= p1_v;
    mem_rsp_data  <= p1_d;
    if (cyc > 150000) begin
      bad = bad + 1;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input int n);
    @(negedge clk);
    host_in = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic set_addr(input logic [18:0] a);
    put({3'b111, a[4:0]}, 8);
    put({3'b011, a[9:5]}, 8);
    put({3'b111, a[14:10]}, 8);
    put({4'b0000, a[18:15]}, 8);
  endtask

  task automatic host_write(input logic [15:0] d);
    put({4'b1010, d[3:0]}, 8);
    put({4'b0010, d[7:4]}, 8);
    put({4'b1010, d[11:8]}, 8);
    put({4'b0000, d[15:12]}, 16);
  endtask

  task automatic host_read(input logic [15:0] exp, input string req);
    put(8'hC0, 16); chk(host_status == exp[3:0],   req, host_status, exp[3:0]);
    put(8'h40, 8);  chk(host_status == exp[7:4],   req, host_status, exp[7:4]);
    put(8'hC0, 8);  chk(host_status == exp[11:8],  req, host_status, exp[11:8]);
    put(8'h00, 8);  chk(host_status == exp[15:12], req, host_status, exp[15:12]);
  endtask

  task automatic apply_settings(input logic [4:0] f);
    put(8'h80, 8);
    put(8'h00, 8);
    put(8'h20, 8);
    put({3'b000, f}, 8);
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'((i * 16'h2F1B) ^ 16'hC35A);
  endfunction

  initial begin
    int w0, r0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(host_status == 0, "R10", host_status, 0);
    chk(ctrl_flags == 0, "R10", ctrl_flags, 0);
    chk(!mem_req_valid, "R10", mem_req_valid, 0);

    // R7 locked: no access, status 0
    w0 = wr_cnt; r0 = rd_cnt;
    host_write(16'h1234);
    chk(wr_cnt == w0, "R7", wr_cnt, w0);
    host_read(16'h0000, "R7");
    chk(rd_cnt == r0, "R7", rd_cnt, r0);

    // R6 settings
    apply_settings(5'b10101);
    chk(ctrl_flags == 5'b10101, "R6", ctrl_flags, 5'b10101);
    chk(host_owns_mem == 1'b1, "R6", host_owns_mem, 1);

    // R7 address did not move while locked: first owned write goes to 0
    host_write(16'hBEEF);
    chk(last_addr == 0, "R7", last_addr, 0);

    // R3 R5 R9 sequential write sweep
    set_addr(19'd0);
    for (int i = 0; i < 16; i++) begin
      w0 = wr_cnt;
      host_write(pat(i));
      chk(wr_cnt == w0 + 1, "R9", wr_cnt, w0 + 1);
      chk(last_addr == 19'(i), "R5", last_addr, i);
      chk(last_wdata == pat(i), "R3", last_wdata, pat(i));
    end

    // R4 R5 read back sweep
    set_addr(19'd0);
    for (int i = 0; i < 16; i++) begin
      r0 = rd_cnt;
      host_read(pat(i), "R4");
      chk(rd_cnt == r0 + 1, "R9", rd_cnt, r0 + 1);
      chk(last_addr == 19'(i), "R5", last_addr, i);
    end

    // R2 every single-bit address plus a mixed one
    for (int k = 0; k < 19; k++) begin
      set_addr(19'(1 << k));
      host_write(16'(k));
      chk(last_addr == 19'(1 << k), "R2", last_addr, 1 << k);
    end
    set_addr(19'h5A5A7);
    host_write(16'h0F0F);
    chk(last_addr == 19'h5A5A7, "R2", last_addr, 19'h5A5A7);

    // R5 wrap
    set_addr(19'h7FFFF);
    host_write(16'h1111);
    host_write(16'h2222);
    chk(last_addr == 19'h00000, "R5", last_addr, 0);

    // R1 bits without strobe change start nothing
    w0 = wr_cnt;
    put(8'h7F, 8);
    put(8'h00, 8);
    chk(wr_cnt == w0, "R1", wr_cnt, w0);
    host_write(16'h3333);
    chk(last_addr == 19'h00001, "R1", last_addr, 1);

    // R8 abort: mismatched slice, then a normal write at the same address
    set_addr(19'd10);
    w0 = wr_cnt;
    put(8'hA5, 8);
    put(8'h00, 16);
    chk(wr_cnt == w0, "R8", wr_cnt, w0);
    host_write(16'h4444);
    chk(last_addr == 19'd10, "R8", last_addr, 10);
    chk(last_wdata == 16'h4444, "R8", last_wdata, 16'h4444);

    // R6 R7 release ownership
    apply_settings(5'b00000);
    chk(ctrl_flags == 0, "R6", ctrl_flags, 0);
    w0 = wr_cnt;
    host_write(16'h5555);
    chk(wr_cnt == w0, "R7", wr_cnt, w0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule